// File: doc/BRIEF.md
# Hierarchical Reset and Power-Down Controller

This block produces the internal reset and power-down controls for a device built from three reset domains: global logic, a single port, and a JTAG test block. It merges an active-low external reset pin, an active-low power-on reset, and a software global-reset bit into one global reset. Below the global reset sits a port reset, which is driven by a port reset bit and by the port power-down sequencer. JTAG has its own reset, fed only by the power-on reset and an active-low JTAG reset pin.

Every reset output asserts asynchronously, as soon as one of its sources becomes active. It releases synchronously through a short flop chain on the system clock. Three registers sit on a small 8-bit address/write/read bus and are part of the block:

- a global control register;
- a port control register;
- a port data register, which stands in for the flops of the port datapath.

Software clears the global reset bit itself. No other reset touches that bit, except power-on.

Top module: `reset_pd_ctrl`

## Requirements
- R1: A low level on `ext_rst_ni` drives `glb_rst_no` and `port_rst_no` low at once, without waiting for a clock edge.
- R2: After every global reset source is inactive, `glb_rst_no` rises on the second rising clock edge. `port_rst_no` rises two edges after that.
- R3: Writing 1 to bit 0 of address 0 asserts the global reset, which stays asserted until software writes 0 there. An external pin reset does not clear this bit.
- R4: While the global reset is active, address 0 bits 7:1, address 1 and address 2 read as 0, and writes to them are lost.
- R5: Bit 0 of address 1 asserts `port_rst_no` and clears the port data register (address 2). It leaves `glb_rst_no` high and the global registers unchanged.
- R6: While bit 1 of address 1 (power-down) is 1, `port_clk_en_o` is 0 and `port_rst_no` is 0. A write to address 2 during power-down has no effect.
- R7: When power-down is cleared, `port_clk_en_o` rises one clock edge later. `port_rst_no` rises WAKE_CYC+2 edges after that (6 with default parameters).
- R8: `jtag_rst_no` follows only `por_ni` and `jtag_rst_ni`. The external pin and the global reset bit do not affect it.
- R9: Addresses 0, 1 and 2 read back the last value written to them. Address 3 always reads 0, and writes to it have no effect.
- R10: A low `por_ni` asserts all three reset outputs at once and clears every register, including the global reset bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| por_ni | input | 1 | Power-on reset, active low |
| ext_rst_ni | input | 1 | External reset pin, active low |
| jtag_rst_ni | input | 1 | JTAG reset pin, active low |
| reg_addr_i | input | 2 | Register address |
| reg_we_i | input | 1 | Register write enable |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| glb_rst_no | output | 1 | Global reset, active low |
| port_rst_no | output | 1 | Port reset, active low |
| port_clk_en_o | output | 1 | Port clock enable |
| jtag_rst_no | output | 1 | JTAG reset, active low |

## Verification
The assertions check the reset hierarchy on every cycle:

- global reset implies port reset;
- the external pin and the global reset bit each force the global reset;
- power-down forces the port clock enable low and the port reset active;
- each global reset release follows a request that was already inactive on the previous edge.

Only the bench scenarios can show the rest. That covers register contents after each reset source, survival of the global reset bit across a pin reset, and JTAG staying out of the global reset. It also covers the exact synchronous release latency and the wake-up ordering and cycle count after power-down.

// File: rtl/reset_pd_pkg.sv
package reset_pd_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_GLB   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_PORT  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_PDATA = 2'd2;

  typedef struct packed {
    logic [6:0] scratch;
    logic       rst;
  } glb_ctrl_t;

  typedef struct packed {
    logic [5:0] scratch;
    logic       pd;
    logic       rst;
  } port_ctrl_t;

  typedef enum logic [1:0] {
    PS_RUN  = 2'd0,
    PS_OFF  = 2'd1,
    PS_WAKE = 2'd2
  } pd_state_e;

  // reset synchronizer slots
  localparam int SYNC_POR  = 0;
  localparam int SYNC_GLB  = 1;
  localparam int SYNC_PORT = 2;
  localparam int SYNC_JTAG = 3;
  localparam int NUM_SYNC  = 4;
endpackage

// File: rtl/reset_pd_sync.sv
module reset_pd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] q;

  // assert async, release through STAGES flops
  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) q <= '0;
    else          q <= {q[STAGES-2:0], 1'b1};
  end

  assign rst_no = q[STAGES-1];
endmodule

// File: rtl/reset_pd_seq.sv
module reset_pd_seq
  import reset_pd_pkg::*;
#(
  parameter int WAKE_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pd_i,
  output logic clk_en_o,
  output logic hold_o
);
  localparam int CNT_W = $clog2(WAKE_CYC + 1);

  pd_state_e        st_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= PS_RUN;
      cnt_q <= '0;
    end else begin
      case (st_q)
        PS_RUN:  if (pd_i) st_q <= PS_OFF;
        PS_OFF:  if (!pd_i) begin
                   st_q  <= PS_WAKE;
                   cnt_q <= '0;
                 end
        PS_WAKE: begin
          if (pd_i)                               st_q  <= PS_OFF;
          else if (cnt_q == CNT_W'(WAKE_CYC - 1)) st_q  <= PS_RUN;
          else                                    cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= PS_RUN;
      endcase
    end
  end

  // power-down takes effect combinationally; wake-up is sequenced
  assign clk_en_o = (st_q != PS_OFF) & ~pd_i;
  assign hold_o   = pd_i | (st_q != PS_RUN);
endmodule

// File: rtl/reset_pd_regs.sv
module reset_pd_regs
  import reset_pd_pkg::*;
(
  input  logic              clk_i,
  input  logic              por_rst_ni,
  input  logic              glb_rst_ni,
  input  logic              port_rst_ni,
  input  logic              port_clk_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output glb_ctrl_t         glb_ctrl_o,
  output port_ctrl_t        port_ctrl_o
);
  logic              glb_bit_q;
  logic [6:0]        glb_scr_q;
  port_ctrl_t        port_ctrl_q;
  logic [DATA_W-1:0] pdata_q;

  logic wr_glb, wr_port, wr_pdata;
  assign wr_glb   = we_i && (addr_i == ADDR_GLB);
  assign wr_port  = we_i && (addr_i == ADDR_PORT);
  assign wr_pdata = we_i && (addr_i == ADDR_PDATA) && port_clk_en_i;

  // global reset bit: power-on only
  always_ff @(posedge clk_i or negedge por_rst_ni) begin
    if (!por_rst_ni)  glb_bit_q <= 1'b0;
    else if (wr_glb)  glb_bit_q <= wdata_i[0];
  end

  always_ff @(posedge clk_i or negedge glb_rst_ni) begin
    if (!glb_rst_ni) begin
      glb_scr_q   <= '0;
      port_ctrl_q <= '0;
    end else begin
      if (wr_glb)  glb_scr_q   <= wdata_i[7:1];
      if (wr_port) port_ctrl_q <= port_ctrl_t'(wdata_i);
    end
  end

  // stands in for port datapath flops
  always_ff @(posedge clk_i or negedge port_rst_ni) begin
    if (!port_rst_ni)  pdata_q <= '0;
    else if (wr_pdata) pdata_q <= wdata_i;
  end

  assign glb_ctrl_o  = '{scratch: glb_scr_q, rst: glb_bit_q};
  assign port_ctrl_o = port_ctrl_q;

  always_comb begin
    case (addr_i)
      ADDR_GLB:   rdata_o = glb_ctrl_o;
      ADDR_PORT:  rdata_o = port_ctrl_q;
      ADDR_PDATA: rdata_o = pdata_q;
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/reset_pd_ctrl.sv
module reset_pd_ctrl
  import reset_pd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WAKE_CYC    = 4
) (
  input  logic              clk_i,
  input  logic              por_ni,
  input  logic              ext_rst_ni,
  input  logic              jtag_rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              glb_rst_no,
  output logic              port_rst_no,
  output logic              port_clk_en_o,
  output logic              jtag_rst_no
);
  glb_ctrl_t  glb_ctrl;
  port_ctrl_t port_ctrl;
  logic       pd_hold;
  logic       glb_req_n;
  logic [NUM_SYNC-1:0] req_n, rst_n;

  assign glb_req_n          = por_ni & ext_rst_ni & ~glb_ctrl.rst;
  assign req_n[SYNC_POR]    = por_ni;
  assign req_n[SYNC_GLB]    = glb_req_n;
  assign req_n[SYNC_PORT]   = rst_n[SYNC_GLB] & ~port_ctrl.rst & ~pd_hold;
  assign req_n[SYNC_JTAG]   = por_ni & jtag_rst_ni;

  for (genvar g = 0; g < NUM_SYNC; g++) begin : g_sync
    reset_pd_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .arst_ni(req_n[g]),
      .rst_no (rst_n[g])
    );
  end

  reset_pd_seq #(.WAKE_CYC(WAKE_CYC)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_n[SYNC_GLB]),
    .pd_i    (port_ctrl.pd),
    .clk_en_o(port_clk_en_o),
    .hold_o  (pd_hold)
  );

  reset_pd_regs u_regs (
    .clk_i        (clk_i),
    .por_rst_ni   (rst_n[SYNC_POR]),
    .glb_rst_ni   (rst_n[SYNC_GLB]),
    .port_rst_ni  (rst_n[SYNC_PORT]),
    .port_clk_en_i(port_clk_en_o),
    .addr_i       (reg_addr_i),
    .we_i         (reg_we_i),
    .wdata_i      (reg_wdata_i),
    .rdata_o      (reg_rdata_o),
    .glb_ctrl_o   (glb_ctrl),
    .port_ctrl_o  (port_ctrl)
  );

  assign glb_rst_no  = rst_n[SYNC_GLB];
  assign port_rst_no = rst_n[SYNC_PORT];
  assign jtag_rst_no = rst_n[SYNC_JTAG];
endmodule

// File: rtl/reset_pd_ctrl_chk.sv
module reset_pd_ctrl_chk (
  input logic clk_i,
  input logic por_ni,
  input logic ext_rst_ni,
  input logic jtag_rst_ni,
  input logic glb_rst_no,
  input logic port_rst_no,
  input logic port_clk_en_o,
  input logic jtag_rst_no,
  input logic glb_bit,
  input logic pd_bit,
  input logic glb_req_n
);
  AST_PIN_FORCES_GLB: assert property (@(posedge clk_i) disable iff (!por_ni)
    !ext_rst_ni |-> !glb_rst_no); // R1
  AST_GLB_FORCES_PORT: assert property (@(posedge clk_i) disable iff (!por_ni)
    !glb_rst_no |-> !port_rst_no); // R1
  AST_GLB_RELEASE_SYNC: assert property (@(posedge clk_i) disable iff (!por_ni)
    $rose(glb_rst_no) |-> $past(glb_req_n)); // R2
  AST_SW_BIT_HOLDS_GLB: assert property (@(posedge clk_i) disable iff (!por_ni)
    glb_bit |-> !glb_rst_no); // R3
  AST_PD_GATES_PORT: assert property (@(posedge clk_i) disable iff (!por_ni)
    pd_bit |-> (!port_clk_en_o && !port_rst_no)); // R6
  AST_WAKE_CLK_FIRST: assert property (@(posedge clk_i) disable iff (!por_ni)
    $rose(port_rst_no) |-> port_clk_en_o); // R7
  AST_JTAG_PIN: assert property (@(posedge clk_i) disable iff (!por_ni)
    !jtag_rst_ni |-> !jtag_rst_no); // R8
endmodule

bind reset_pd_ctrl reset_pd_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .por_ni       (por_ni),
  .ext_rst_ni   (ext_rst_ni),
  .jtag_rst_ni  (jtag_rst_ni),
  .glb_rst_no   (glb_rst_no),
  .port_rst_no  (port_rst_no),
  .port_clk_en_o(port_clk_en_o),
  .jtag_rst_no  (jtag_rst_no),
  .glb_bit      (glb_ctrl.rst),
  .pd_bit       (port_ctrl.pd),
  .glb_req_n    (glb_req_n)
);

// File: tb/tb_reset_pd_ctrl.sv
`timescale 1ns/100ps
module tb_reset_pd_ctrl;
  localparam int WAKE_CYC = 4;
  localparam int NVEC = 9;
  // {we, addr[1:0], wdata[7:0], exp[7:0]}
  localparam logic [18:0] VEC [NVEC] = '{
    {1'b1, 2'd0, 8'hA8, 8'h00},
    {1'b0, 2'd0, 8'h00, 8'hA8},
    {1'b1, 2'd1, 8'hF0, 8'h00},
    {1'b0, 2'd1, 8'h00, 8'hF0},
    {1'b1, 2'd2, 8'h5A, 8'h00},
    {1'b0, 2'd2, 8'h00, 8'h5A},
    {1'b1, 2'd3, 8'hFF, 8'h00},
    {1'b0, 2'd3, 8'h00, 8'h00},
    {1'b0, 2'd0, 8'h00, 8'hA8}
  };

  logic       clk_i = 1'b0;
  logic       por_ni = 1'b1, ext_rst_ni = 1'b1, jtag_rst_ni = 1'b1;
  logic [1:0] reg_addr_i = '0;
  logic       reg_we_i = 1'b0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic       glb_rst_no, port_rst_no, port_clk_en_o, jtag_rst_no;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  reset_pd_ctrl #(.WAKE_CYC(WAKE_CYC)) dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk_i);
    reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1'b1;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(string req, logic [1:0] a, logic [7:0] exp);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 chk(req, reg_rdata_o, exp);
  endtask

  task automatic edge_s;
    @(posedge clk_i); #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1 por_ni = 1'b0;
    #1;
    chk("R10 por glb",  glb_rst_no,  1'b0);
    chk("R10 por port", port_rst_no, 1'b0);
    chk("R10 por jtag", jtag_rst_no, 1'b0);
    repeat (2) @(negedge clk_i);
    por_ni = 1'b1;
    edge_s; chk("R2 glb held edge1", glb_rst_no, 1'b0);
    edge_s; chk("R2 glb free edge2", glb_rst_no, 1'b1);
    chk("R8 jtag free", jtag_rst_no, 1'b1);
    chk("R2 port held", port_rst_no, 1'b0);
    edge_s; edge_s; chk("R2 port free", port_rst_no, 1'b1);
    rd("R10 addr0 default", 2'd0, 8'h00);
    rd("R10 addr1 default", 2'd1, 8'h00);

    // R9 register vectors
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][18]) wr(VEC[i][17:16], VEC[i][15:8]);
      else            rd("R9 vector", VEC[i][17:16], VEC[i][7:0]);
    end

    // R5 port reset bit
    wr(2'd1, 8'h01);
    chk("R5 port asserted", port_rst_no, 1'b0);
    chk("R5 glb untouched", glb_rst_no, 1'b1);
    rd("R5 pdata cleared", 2'd2, 8'h00);
    rd("R5 glb reg kept", 2'd0, 8'hA8);
    wr(2'd1, 8'h00);
    edge_s; edge_s;
    chk("R5 port released", port_rst_no, 1'b1);

    // R6 power-down
    wr(2'd2, 8'h11);
    wr(2'd1, 8'h02);
    chk("R6 clk_en low", port_clk_en_o, 1'b0);
    chk("R6 port held", port_rst_no, 1'b0);
    wr(2'd2, 8'h33);
    rd("R6 pdata write ignored", 2'd2, 8'h00);
    rd("R6 ctrl readback", 2'd1, 8'h02);

    // R7 wake ordering
    wr(2'd1, 8'h00);
    chk("R7 clk_en still low", port_clk_en_o, 1'b0);
    edge_s;
    chk("R7 clk_en first", port_clk_en_o, 1'b1);
    chk("R7 port still reset", port_rst_no, 1'b0);
    begin
      int n = 0;
      while (!port_rst_no && n < 50) begin edge_s; n++; end
      chk("R7 wake gap", n, WAKE_CYC + 2);
    end
    wr(2'd2, 8'h3C);
    rd("R7 port live", 2'd2, 8'h3C);

    // R3 / R4 software global reset
    wr(2'd1, 8'hC0);
    wr(2'd0, 8'hA9);
    chk("R3 glb asserted", glb_rst_no, 1'b0);
    chk("R3 port follows", port_rst_no, 1'b0);
    chk("R8 jtag unaffected sw", jtag_rst_no, 1'b1);
    rd("R4 addr0 only bit", 2'd0, 8'h01);
    rd("R4 addr1 cleared", 2'd1, 8'h00);
    rd("R4 addr2 cleared", 2'd2, 8'h00);
    wr(2'd1, 8'h40);
    rd("R4 write lost", 2'd1, 8'h00);
    repeat (10) edge_s;
    chk("R3 still asserted", glb_rst_no, 1'b0);
    @(negedge clk_i); ext_rst_ni = 1'b0;
    @(negedge clk_i); ext_rst_ni = 1'b1;
    rd("R3 bit survives pin", 2'd0, 8'h01);
    wr(2'd0, 8'h00);
    chk("R3 held after clear", glb_rst_no, 1'b0);
    edge_s; chk("R2 sw release edge1", glb_rst_no, 1'b0);
    edge_s; chk("R3 released", glb_rst_no, 1'b1);

    // R1 async pin assert, R8 jtag isolation
    wr(2'd0, 8'h54);
    @(negedge clk_i); #1 ext_rst_ni = 1'b0;
    #0.5;
    chk("R1 glb async", glb_rst_no, 1'b0);
    chk("R1 port async", port_rst_no, 1'b0);
    chk("R8 jtag ignores pin", jtag_rst_no, 1'b1);
    rd("R4 pin clears scratch", 2'd0, 8'h00);
    @(negedge clk_i); ext_rst_ni = 1'b1;
    edge_s; chk("R2 pin edge1", glb_rst_no, 1'b0);
    edge_s; chk("R2 pin edge2", glb_rst_no, 1'b1);

    @(negedge clk_i); #1 jtag_rst_ni = 1'b0;
    #0.5;
    chk("R8 jtag pin async", jtag_rst_no, 1'b0);
    chk("R8 glb ignores jtag", glb_rst_no, 1'b1);
    @(negedge clk_i); jtag_rst_ni = 1'b1;
    edge_s; edge_s;
    chk("R8 jtag release", jtag_rst_no, 1'b1);

    // R10 power-on clears glb bit
    repeat (4) edge_s;
    wr(2'd0, 8'h01);
    @(negedge clk_i); #1 por_ni = 1'b0;
    #0.5;
    chk("R10 jtag on por", jtag_rst_no, 1'b0);
    rd("R10 bit cleared", 2'd0, 8'h00);
    @(negedge clk_i); por_ni = 1'b1;
    repeat (5) edge_s;
    chk("R10 glb released", glb_rst_no, 1'b1);
    chk("R10 port released", port_rst_no, 1'b1);
    chk("R10 clk_en", port_clk_en_o, 1'b1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule